// File: doc/BRIEF.md
# Three-Mode LED Step Sequencer

This block drives an eight-segment LED bar from a small up/down counter. Three push-button inputs pick how the counter moves. Up steps it upward and wraps from 7 back to 0. Down steps it downward and wraps from 0 back to 7. Bounce sweeps it back and forth between 0 and 7. The count moves only when a timer tick input is high, so an external divider sets the speed of the pattern.

A control FSM turns each button press into a mode and sends a small set of strobes to the datapath: step now, and which way. The datapath holds the count and reports when it sits at its lowest or highest value. In bounce mode the FSM uses those two flags to reverse direction. A mode change keeps the current count, and the new mode continues from that value. Buttons are assumed to be debounced before they reach the block.

Top module: `bounce_sequencer`

## Requirements
- R1: After reset the count is 0 and the bar is 8'h01. No mode is active, and ticks leave the count unchanged until a button press selects a mode.
- R2: A press is a cycle in which a button input is high and was low in the previous cycle. Holding a button high has no further effect. The most recent press selects the mode. When presses arrive in the same cycle, bounce wins over down, and down wins over up.
- R3: The count changes only at a clock edge where tick is high and a mode is active, and only by one step modulo 8. Without a tick the count holds.
- R4: In up mode each tick adds one to the count, and 7 wraps to 0.
- R5: In down mode each tick subtracts one from the count, and 0 wraps to 7.
- R6: In bounce mode the count moves back and forth between 0 and 7. It turns around at 7 and at 0, never wraps, and never holds an end value for two ticks.
- R7: When bounce mode is entered, the first step goes down if the count is 7. Otherwise the first step goes up.
- R8: Selecting a mode keeps the current count. A press in the same cycle as a tick already governs that tick's step.
- R9: Bit i of the bar is 1 exactly when i is less than or equal to the count, so the bar is a thermometer code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous reset, active high |
| upBtn | input | 1 | Debounced level of the up button |
| downBtn | input | 1 | Debounced level of the down button |
| bounceBtn | input | 1 | Debounced level of the bounce button |
| tick | input | 1 | One-cycle pulse that marks the end of a timer interval |
| count | output | 3 | Current counter value |
| bar | output | 8 | LED bar pattern (thermometer code of count) |

## Verification
The hardest cases to reach are bounce entry at every possible count, and above all entry at 7, where the first step has to go down. To reach them, the stimulus drives the counter in up mode until it holds each start value 0 to 7, then presses bounce and follows two full sweeps. Further cases are a press that shares a cycle with a tick, a button held high while a different one is pressed, and presses that coincide in one cycle. Each of these tests the edge detection and the priority order.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CNT_W = 3;
  localparam int BAR_W = 1 << CNT_W;
  localparam int BTN_N = 3;

  typedef enum logic [1:0] {
    MODE_NONE,
    MODE_UP,
    MODE_DOWN,
    MODE_BOUNCE
  } seq_mode_e;

  typedef struct packed {
    logic step;
    logic goUp;
  } seq_strobe_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int W = CNT_W,
  localparam int B = 1 << W
) (
  input  logic         clk,
  input  logic         reset,
  input  seq_strobe_t  strobe,
  output logic [W-1:0] count,
  output logic         atMin,
  output logic         atMax,
  output logic [B-1:0] bar
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (reset) begin
      count <= '0;
    end else if (strobe.step) begin
      count <= strobe.goUp ? count + ONE : count - ONE;
    end
  end

  assign atMax = &count;
  assign atMin = ~|count;

  for (genvar g = 0; g < B; g++) begin : gBar
    assign bar[g] = (int'(count) >= g);
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        reset,
  input  logic        upBtn,
  input  logic        downBtn,
  input  logic        bounceBtn,
  input  logic        tick,
  input  logic        atMin,
  input  logic        atMax,
  output seq_mode_e   modeNow,
  output seq_strobe_t strobe
);
  logic [BTN_N-1:0] btnNow;
  logic [BTN_N-1:0] btnPrev;
  logic [BTN_N-1:0] rise;
  seq_mode_e        modeReg;
  seq_mode_e        effMode;
  logic             dirUp;
  logic             dirBase;
  logic             dirEff;
  logic             bounceEntry;

  assign btnNow = {bounceBtn, downBtn, upBtn};
  assign rise   = btnNow & ~btnPrev;
  assign bounceEntry = rise[2];

  always_comb begin
    effMode = modeReg;
    if (rise[2])      effMode = MODE_BOUNCE;
    else if (rise[1]) effMode = MODE_DOWN;
    else if (rise[0]) effMode = MODE_UP;
  end

  always_comb begin
    dirBase = bounceEntry ? 1'b1 : dirUp;
    if (dirBase && atMax)       dirEff = 1'b0;
    else if (!dirBase && atMin) dirEff = 1'b1;
    else                        dirEff = dirBase;
  end

  always_comb begin
    strobe.step = tick && (effMode != MODE_NONE);
    case (effMode)
      MODE_UP:     strobe.goUp = 1'b1;
      MODE_DOWN:   strobe.goUp = 1'b0;
      MODE_BOUNCE: strobe.goUp = dirEff;
      default:     strobe.goUp = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      btnPrev <= '0;
      modeReg <= MODE_NONE;
      dirUp   <= 1'b1;
    end else begin
      btnPrev <= btnNow;
      modeReg <= effMode;
      if (bounceEntry) dirUp <= 1'b1;
      if (tick && effMode == MODE_BOUNCE) dirUp <= dirEff;
    end
  end

  assign modeNow = modeReg;
endmodule

// File: rtl/bounce_sequencer.sv
module bounce_sequencer
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             reset,
  input  logic             upBtn,
  input  logic             downBtn,
  input  logic             bounceBtn,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [BAR_W-1:0] bar
);
  seq_strobe_t strobe;
  seq_mode_e   modeNow;
  logic        atMin;
  logic        atMax;

  seq_control uCtrl (
    .clk(clk), .reset(reset), .upBtn(upBtn), .downBtn(downBtn),
    .bounceBtn(bounceBtn), .tick(tick), .atMin(atMin), .atMax(atMax),
    .modeNow(modeNow), .strobe(strobe)
  );

  seq_datapath #(.W(CNT_W)) uPath (
    .clk(clk), .reset(reset), .strobe(strobe), .count(count),
    .atMin(atMin), .atMax(atMax), .bar(bar)
  );
endmodule

// File: rtl/bounce_sequencer_chk.sv
module bounce_sequencer_chk
  import seq_pkg::*;
(
  input logic             clk,
  input logic             reset,
  input logic             upBtn,
  input logic             downBtn,
  input logic             bounceBtn,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [BAR_W-1:0] bar,
  input seq_mode_e        modeNow
);
  logic noBtn;
  assign noBtn = !upBtn && !downBtn && !bounceBtn;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (reset)
    (modeNow == MODE_NONE && noBtn) |=> $stable(count)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (reset)
    !tick |=> $stable(count)); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (reset)
    1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)
              || count == CNT_W'($past(count) - 1'b1))); // R3

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (reset)
    (tick && modeNow == MODE_UP && noBtn) |=> count == CNT_W'($past(count) + 1'b1)); // R4

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (reset)
    (tick && modeNow == MODE_DOWN && noBtn) |=> count == CNT_W'($past(count) - 1'b1)); // R5

  AST_BOUNCE_NO_WRAP: assert property (@(posedge clk) disable iff (reset)
    (tick && modeNow == MODE_BOUNCE && noBtn) |=>
      !(($past(count) == '1 && count == '0) || ($past(count) == '0 && count == '1))); // R6

  AST_BAR_THERMO: assert property (@(posedge clk) disable iff (reset)
    ($countones(bar) == int'(count) + 1) && bar[0]); // R9
endmodule

bind bounce_sequencer bounce_sequencer_chk uChk (
  .clk(clk), .reset(reset), .upBtn(upBtn), .downBtn(downBtn),
  .bounceBtn(bounceBtn), .tick(tick), .count(count), .bar(bar),
  .modeNow(modeNow)
);

// File: tb/bounce_sequencer_test.sv
module bounce_sequencer_test;
  logic       clk = 1'b0;
  logic       reset = 1'b1;
  logic       upBtn = 1'b0, downBtn = 1'b0, bounceBtn = 1'b0, tick = 1'b0;
  logic [2:0] count;
  logic [7:0] bar;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: 0 none, 1 up, 2 down, 3 bounce
  int mMode = 0;
  int mCnt = 0;
  bit mDir = 1'b1;
  bit pU = 1'b0, pD = 1'b0, pB = 1'b0;

  always #2.5 clk = ~clk;

  bounce_sequencer uut (
    .clk(clk), .reset(reset), .upBtn(upBtn), .downBtn(downBtn),
    .bounceBtn(bounceBtn), .tick(tick), .count(count), .bar(bar)
  );

  function automatic logic [7:0] thermo(int c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i <= c);
    return r;
  endfunction

  task automatic check(string tag);
    checks++;
    if (int'(count) != mCnt) begin
      errors++;
      $display("FAIL %s: count actual %0d expected %0d", tag, count, mCnt);
    end
    checks++;
    if (bar !== thermo(mCnt)) begin
      errors++;
      $display("FAIL R9 (%s): bar actual %b expected %b", tag, bar, thermo(mCnt));
    end
  endtask

  // one clock cycle with the given input levels; model updated from spec
  task automatic cyc(bit u, bit d, bit b, bit t);
    bit rU, rD, rB;
    @(negedge clk);
    upBtn = u; downBtn = d; bounceBtn = b; tick = t;
    rU = u && !pU; rD = d && !pD; rB = b && !pB;
    pU = u; pD = d; pB = b;
    if (rB) begin mMode = 3; mDir = 1'b1; end
    else if (rD) mMode = 2;
    else if (rU) mMode = 1;
    if (t) begin
      case (mMode)
        1: mCnt = (mCnt + 1) % 8;
        2: mCnt = (mCnt + 7) % 8;
        3: begin
          if (mDir && mCnt == 7) mDir = 1'b0;
          else if (!mDir && mCnt == 0) mDir = 1'b1;
          mCnt = mDir ? mCnt + 1 : mCnt - 1;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    upBtn = 1'b0; downBtn = 1'b0; bounceBtn = 1'b0; tick = 1'b0;
    pU = 1'b0; pD = 1'b0; pB = 1'b0;
  endtask

  task automatic tickN(int n, string tag);
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check(tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    reset = 1'b0;
    @(negedge clk);
    check("R1 reset state");
    tickN(3, "R1 ticks ignored before any press");

    // R4 up sweep
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 press keeps count");
    tickN(20, "R4 up wrap");

    // R3 no tick holds
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R3 hold without tick");
    end

    // R5 down sweep
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    tickN(20, "R5 down wrap");

    // R2 held button: hold down high across ticks, then press up while held
    @(negedge clk);
    downBtn = 1'b1; upBtn = 1'b0; tick = 1'b0;
    mMode = 2;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      tick = 1'b1;
      mCnt = (mCnt + 7) % 8;
      @(negedge clk);
      tick = 1'b0;
      check("R2 held button no repress");
    end
    upBtn = 1'b1;
    @(negedge clk);
    mMode = 1;
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1;
      mCnt = (mCnt + 1) % 8;
      @(negedge clk);
      tick = 1'b0;
      check("R2 later press wins while other held");
    end
    upBtn = 1'b0; downBtn = 1'b0;
    @(negedge clk);

    // R2 simultaneous priority
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    tickN(3, "R2 down beats up");
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    tickN(3, "R2 bounce beats down");

    // R8 press in same cycle as tick
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    check("R8 press with tick applies at once");
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 press with tick applies at once");

    // R6/R7 bounce from every start value
    for (int s = 0; s < 8; s++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 8 && mCnt != s; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R8 reach start value");
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 bounce entry keeps count");
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      checks++;
      if (int'(count) != ((s == 7) ? 6 : s + 1)) begin
        errors++;
        $display("FAIL R7: first bounce step actual %0d expected %0d",
                 count, (s == 7) ? 6 : s + 1);
      end
      check("R7 first bounce step");
      tickN(16, "R6 bounce ping-pong");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule